// File: doc/BRIEF.md
# Line Drive Soft-Start Controller

This block produces the horizontal drive pulse of a deflection controller. Each time the line-start strobe arrives, it emits one pulse whose width in clocks is the current duty. In steady running the duty is about 52% of a line. After a start command, or after a flash (arc) event, the duty does not jump to full width. It climbs from about 5% to about 52% in equal fixed-point steps, one step per line, over a programmable number of lines. This protects the output stage.

An enable level from the control register stops the drive when low, and its rising edge begins a soft start. An over-voltage comparator level is synchronised and reported as a status-set request. With the protection-mode bit set, the same condition also shuts the drive down. The drive then stays down until software drops and re-raises the enable. With the protection-mode bit clear, the condition is only reported. A falling edge on the active-low flash input, taken after a two-flop synchroniser, restarts the ramp from its first step. The block also gives a drive-active indication, which other drive outputs use to gate themselves.

Top module: `line_drive_softstart`

## Requirements
- R1: After reset, `drive_pulse`, `drive_active` and `ovp_flag` are 0. A `start_en` held high through reset does not start the drive: a 0-to-1 change of `start_en` is needed.
- R2: A 0-to-1 change of `start_en` (with no tripping over-voltage) sets `drive_active`. The first line after it uses the start duty START = (LINE_CLKS*5+50)/100 clocks.
- R3: During the ramp, line k (k = 0 to RAMP_LINES-1, counted from the restart) has a duty of (START*2^FRAC_BITS + k*INC) >> FRAC_BITS. Here INC = ((FULL-START)*2^FRAC_BITS)/RAMP_LINES, with integer division.
- R4: Once RAMP_LINES ramp lines have been driven, every following line uses the full duty FULL = (LINE_CLKS*52+50)/100 clocks.
- R5: Each strobe taken while the drive is active gives one pulse. The pulse is high from the clock after the strobe for exactly the duty in clocks.
- R6: While `start_en` is 0 the drive is stopped. `drive_pulse` and `drive_active` fall at most two clocks after `start_en` falls, even in the middle of a pulse.
- R7: A falling edge of `arc_n` while the drive is ramping or running restarts the ramp at line k = 0. This also applies to a second edge during a ramp.
- R8: A falling edge of `arc_n` has no effect while the drive is stopped or tripped.
- R9: With `protect_mode` = 1 and the synchronised over-voltage level high, the drive trips: `drive_pulse` and `drive_active` go to 0. The drive stays off after the over-voltage clears, until `start_en` goes to 0 and back to 1. That change starts a fresh ramp.
- R10: With `protect_mode` = 0, over-voltage does not stop or restart the drive. The ramp continues.
- R11: `ovp_flag` follows `ovp_level` through a two-flop synchroniser and one output register. This holds regardless of `protect_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | One-clock pulse at the start of each line |
| start_en | input | 1 | Drive enable; its rise begins a soft start |
| protect_mode | input | 1 | 1: over-voltage trips the drive; 0: report only |
| ovp_level | input | 1 | Over-voltage comparator level (asynchronous) |
| arc_n | input | 1 | Active-low flash comparator output (asynchronous) |
| drive_pulse | output | 1 | Horizontal drive pulse, high = conducting |
| ovp_flag | output | 1 | Request to set the over-voltage status bit |
| drive_active | output | 1 | High while the drive is ramping or running |

## Verification
The assertions assume the following about the inputs:
- `line_strobe` is a single-clock pulse.
- Strobes are spaced farther apart than the full duty, so a pulse ends before the next strobe reloads it.
- A flash or over-voltage event never lands in the same clock as a strobe.

The stimulus keeps to these assumptions:
- It issues strobes exactly one line apart, from a line task.
- It applies the asynchronous inputs only in idle gaps between lines.
- It waits out the synchroniser latency before the next strobe.

A reduced configuration (40-clock line, 16-line ramp, 8 fraction bits) lets the bench walk every ramp step and the full-duty lines after it.

// File: rtl/lds_pkg.sv
package lds_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_RAMP = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_TRIP = 2'd3
    } drive_mode_e;

    typedef struct packed {
        logic restart;
        logic tick;
    } ramp_ctl_t;

    function automatic int pct_of_line(input int line_clks, input int pct);
        return (line_clks * pct + 50) / 100;
    endfunction

    function automatic int ramp_increment(input int lo, input int hi,
                                          input int frac, input int lines);
        return ((hi - lo) * (1 << frac)) / lines;
    endfunction

endpackage

// File: rtl/lds_sync.sv
module lds_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL[b]}};
                else     chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lds_ramp.sv
module lds_ramp
    import lds_pkg::*;
#(
    parameter int LINE_CLKS  = 432,
    parameter int RAMP_LINES = 2000,
    parameter int FRAC_BITS  = 16,
    localparam int DUTY_W    = $clog2(LINE_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_ctl_t         ctl,
    output logic [DUTY_W-1:0] duty,
    output logic              done
);
    localparam int START  = pct_of_line(LINE_CLKS, 5);
    localparam int FULL   = pct_of_line(LINE_CLKS, 52);
    localparam int INC    = ramp_increment(START, FULL, FRAC_BITS, RAMP_LINES);
    localparam int ACC_W  = DUTY_W + FRAC_BITS;
    localparam int CNT_W  = $clog2(RAMP_LINES + 1);
    localparam logic [ACC_W-1:0] ACC_START = ACC_W'(START) << FRAC_BITS;
    localparam logic [ACC_W-1:0] ACC_INC   = ACC_W'(INC);

    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] lines;

    assign done = (lines == CNT_W'(RAMP_LINES));
    assign duty = done ? DUTY_W'(FULL) : acc[ACC_W-1:FRAC_BITS];

    always_ff @(posedge clk) begin
        if (rst || ctl.restart) begin
            acc   <= ACC_START;
            lines <= '0;
        end else if (ctl.tick && !done) begin
            acc   <= acc + ACC_INC;
            lines <= lines + 1'b1;
        end
    end

    // R3: the duty never falls except at a restart
    assert_ramp_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl.restart |=> duty >= $past(duty));

    // R4: once finished, the duty holds at full until a restart
    assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !ctl.restart) |=> (done && duty == DUTY_W'(FULL)));
endmodule

// File: rtl/lds_pulse.sv
module lds_pulse #(
    parameter int DUTY_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty,
    output logic              pulse
);
    logic [DUTY_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !en)          remain <= '0;
        else if (load)           remain <= duty;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);

    // R5: a pulse only begins right after a strobe load
    assert_pulse_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(load));
endmodule

// File: rtl/line_drive_softstart.sv
module line_drive_softstart
    import lds_pkg::*;
#(
    parameter int LINE_CLKS  = 432,
    parameter int RAMP_LINES = 2000,
    parameter int FRAC_BITS  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic line_strobe,
    input  logic start_en,
    input  logic protect_mode,
    input  logic ovp_level,
    input  logic arc_n,
    output logic drive_pulse,
    output logic ovp_flag,
    output logic drive_active
);
    localparam int DUTY_W = $clog2(LINE_CLKS + 1);

    drive_mode_e       mode_q, mode_d;
    logic              start_q;
    logic [1:0]        sync_out;
    logic              ovp_s, arc_s, arc_q, arc_fall;
    logic              run_state, restart;
    logic [DUTY_W-1:0] duty;
    logic              ramp_done;
    ramp_ctl_t         ctl;

    lds_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst(rst), .d({arc_n, ovp_level}), .q(sync_out));

    assign ovp_s = sync_out[0];
    assign arc_s = sync_out[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_STOP;
            start_q  <= 1'b1;
            arc_q    <= 1'b1;
            ovp_flag <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            start_q  <= start_en;
            arc_q    <= arc_s;
            ovp_flag <= ovp_s;
        end
    end

    assign arc_fall  = arc_q & ~arc_s;
    assign run_state = (mode_q == MODE_RAMP) || (mode_q == MODE_RUN);

    always_comb begin
        mode_d  = mode_q;
        restart = 1'b0;
        if (!start_en) begin
            mode_d = MODE_STOP;
        end else if (protect_mode && ovp_s) begin
            mode_d = MODE_TRIP;
        end else begin
            unique case (mode_q)
                MODE_STOP: if (!start_q) begin
                    mode_d  = MODE_RAMP;
                    restart = 1'b1;
                end
                MODE_RAMP: if (arc_fall) begin
                    restart = 1'b1;
                end else if (ramp_done) begin
                    mode_d = MODE_RUN;
                end
                MODE_RUN: if (arc_fall) begin
                    mode_d  = MODE_RAMP;
                    restart = 1'b1;
                end
                MODE_TRIP: mode_d = MODE_TRIP;
                default:   mode_d = MODE_STOP;
            endcase
        end
    end

    assign ctl.restart = restart;
    assign ctl.tick    = line_strobe & run_state;

    lds_ramp #(.LINE_CLKS(LINE_CLKS), .RAMP_LINES(RAMP_LINES), .FRAC_BITS(FRAC_BITS)) u_ramp (
        .clk(clk), .rst(rst), .ctl(ctl), .duty(duty), .done(ramp_done));

    lds_pulse #(.DUTY_W(DUTY_W)) u_pulse (
        .clk(clk), .rst(rst), .en(run_state), .load(ctl.tick),
        .duty(duty), .pulse(drive_pulse));

    assign drive_active = run_state;

    // R6: no drive pulse once the mode has left ramp/run
    assert_no_drive_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        !run_state |=> !drive_pulse);

    // R9: a trip persists while the enable stays high
    assert_trip_latched_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TRIP && start_en) |=> mode_q == MODE_TRIP);

    // R10: in report-only mode over-voltage leaves a running drive running
    assert_detect_only_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && !protect_mode && start_en && !arc_fall) |=> mode_q == MODE_RUN);

    // R4: full-duty running is only reached with the ramp finished
    assert_run_after_ramp_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN) |-> ramp_done);
endmodule

// File: tb/tb_line_drive_softstart.sv
module tb_line_drive_softstart;
    localparam int LINE  = 40;
    localparam int RL    = 16;
    localparam int FB    = 8;
    localparam int START = (LINE * 5 + 50) / 100;
    localparam int FULL  = (LINE * 52 + 50) / 100;
    localparam int INC   = ((FULL - START) * (1 << FB)) / RL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_strobe = 1'b0, start_en = 1'b1, protect_mode = 1'b0;
    logic ovp_level = 1'b0, arc_n = 1'b1;
    logic drive_pulse, ovp_flag, drive_active;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    line_drive_softstart #(.LINE_CLKS(LINE), .RAMP_LINES(RL), .FRAC_BITS(FB)) dut (
        .clk(clk), .rst(rst), .line_strobe(line_strobe), .start_en(start_en),
        .protect_mode(protect_mode), .ovp_level(ovp_level), .arc_n(arc_n),
        .drive_pulse(drive_pulse), .ovp_flag(ovp_flag), .drive_active(drive_active));

    function automatic int ramp_duty(input int k);
        if (k >= RL) return FULL;
        return (START * (1 << FB) + k * INC) >> FB;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one line: strobe, then count drive clocks; R5 checks the first sample too
    task automatic run_line(input string req, input int exp);
        int cnt = 0;
        int first;
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
        first = drive_pulse;
        for (int i = 0; i < LINE - 1; i++) begin
            if (drive_pulse) cnt++;
            @(negedge clk);
        end
        check(req, cnt, exp);
        if (exp > 0) check("R5 pulse starts after strobe", first, 1);
    endtask

    task automatic arc_event();
        arc_n = 1'b0;
        repeat (4) @(negedge clk);
        arc_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 drive_pulse reset", drive_pulse, 0);
        check("R1 drive_active reset", drive_active, 0);
        check("R1 ovp_flag reset", ovp_flag, 0);
        run_line("R1 no start without rise", 0);
        check("R1 still inactive", drive_active, 0);

        start_en = 1'b0;
        repeat (3) @(negedge clk);
        start_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 active after rise", drive_active, 1);
        run_line("R2 first line start duty", START);
        for (int k = 1; k < RL; k++) run_line("R3 ramp step", ramp_duty(k));
        for (int k = 0; k < 3; k++) run_line("R4 full duty", FULL);

        arc_event();
        check("R7 active after flash", drive_active, 1);
        for (int k = 0; k < 5; k++) run_line("R7 restart from run", ramp_duty(k));
        arc_event();
        for (int k = 0; k < 3; k++) run_line("R7 second flash in ramp", ramp_duty(k));

        protect_mode = 1'b0;
        ovp_level = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 flag set", ovp_flag, 1);
        check("R10 still active", drive_active, 1);
        run_line("R10 ramp continues", ramp_duty(3));
        ovp_level = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 flag clear", ovp_flag, 0);
        run_line("R10 ramp continues after", ramp_duty(4));

        protect_mode = 1'b1;
        ovp_level = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 trip inactive", drive_active, 0);
        check("R11 flag in protect", ovp_flag, 1);
        run_line("R9 no drive tripped", 0);
        ovp_level = 1'b0;
        repeat (5) @(negedge clk);
        run_line("R9 stays off after clear", 0);
        arc_event();
        run_line("R8 flash ignored tripped", 0);
        check("R8 inactive tripped", drive_active, 0);

        start_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 inactive stopped", drive_active, 0);
        arc_event();
        run_line("R8 flash ignored stopped", 0);
        start_en = 1'b1;
        repeat (3) @(negedge clk);
        run_line("R9 fresh ramp after re-enable", ramp_duty(0));
        run_line("R9 second line of fresh ramp", ramp_duty(1));

        for (int k = 2; k < RL + 1; k++) run_line("R4 reach full", ramp_duty(k));
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
        @(negedge clk);
        check("R6 pulse running before stop", drive_pulse, 1);
        start_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 pulse off within two clocks", drive_pulse, 0);
        check("R6 active off within two clocks", drive_active, 0);
        repeat (LINE) @(negedge clk);
        run_line("R6 stopped line", 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule